// File: doc/BRIEF.md
# Wavefront Path-Planning Grid Cell

This block is one processing element of a two-dimensional grid that finds least-cost routes by letting a trigger wave spread across the terrain. Each cell stands for one terrain pixel. It holds an 8-bit traversal cost and a 4-bit mask of edges that the wave may not cross. It has one trigger input from each of its four neighbours and one trigger output to each of them. The first trigger that reaches an idle cell is accepted and recorded as a single direction flag, and every later trigger is shut out. The cell then waits for its cost in clock cycles and pulses its outgoing triggers. Outputs whose block bit is set stay low.

After the wave has settled, the stored direction flags are read cell by cell to walk back from any destination to the nearest source. The host programs the cell and reads it back through a narrow data path. A select input qualifies each access, a function code picks the cost, the block mask or the direction flags, and a nibble bit picks which half of the cost is accessed. A source cell starts a wave without recording a direction. A global clear gets the grid ready for the next run and keeps the programmed terrain.

Top module: `wave_cell`

## Requirements
- R1: While reset is held and right after it is released, `trig_out_o` is 0 and the cost, the block mask and the direction flags all read back as 0.
- R2: Function code 00 accesses the cost. `nib_i`=0 selects cost bits 3:0 and `nib_i`=1 selects bits 7:4. A cost write takes effect only while the cell has not been reached; otherwise the cost is unchanged.
- R3: When an unreached cell samples a non-zero `trig_in_i` (bit 0 north, 1 east, 2 south, 3 west), it sets exactly one direction flag, at the same bit position. The flag chosen is the lowest set bit, which gives the priority north, east, south, west.
- R4: Once a cell has been reached, it ignores later triggers: its direction flags do not change and no second pulse is issued.
- R5: Suppose an arrival is captured at clock edge k with cost C. Then `trig_out_o` is high for exactly the one cycle between edges k+C and k+C+1. A cost of 0 therefore pulses right after the capture edge.
- R6: Function code 01 accesses the block mask, and the mask may be written at any time. A 1 in bit d holds `trig_out_o[d]` low during the pulse.
- R7: `src_i` on an unreached cell marks it reached with no direction flag. It pulses between edges k and k+1, whatever the cost. If `src_i` and a trigger arrive on the same edge, `src_i` wins.
- R8: `clear_i` is synchronous and overrides arrivals and `src_i`. It clears the direction flags and the reached state, and it cancels any pending pulse. The cost and the block mask are kept.
- R9: `rdata_o` is combinational. It is 0 when `sel_i`=0 and 0 for function code 11. Function code 10 returns the direction flags, and they can be read at any time, including during a countdown.
- R10: A write needs both `sel_i` and `we_i`. Writes with function code 10 or 11 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset: asserted asynchronously, released synchronously |
| clear_i | input | 1 | Synchronous run clear (keeps the cost and block mask) |
| src_i | input | 1 | Starts a wave from this cell |
| trig_in_i | input | 4 | Neighbour triggers: N, E, S, W on bits 0..3 |
| trig_out_o | output | 4 | Outgoing triggers: N, E, S, W on bits 0..3 |
| sel_i | input | 1 | Cell select for register access |
| we_i | input | 1 | Write strobe |
| func_i | input | 2 | 00 cost, 01 block mask, 10 direction flags, 11 none |
| nib_i | input | 1 | Cost nibble select |
| wdata_i | input | BUS_W | Write data |
| rdata_o | output | BUS_W | Read data |

## Verification
An arrival or source sampled at edge k is due on `trig_out_o` in the cycle that begins at edge k+C, where C is the cost, or at edge k for a source. Writes and flag captures show up on `rdata_o` in the cycle after their edge. Reads with the same registers unchanged appear within the same cycle. The bench runs an event-time model: it notes the edge number at which each pulse is due and compares both outputs at every falling edge. All inputs change one nanosecond after the rising edge, so every comparison lands midway between the edge that causes a result and the next one.

// File: rtl/wave_cell_pkg.sv
package wave_cell_pkg;
  localparam int NDIR = 4;
  // direction bit positions; index order is also arrival priority
  localparam int DIR_N = 0;
  localparam int DIR_E = 1;
  localparam int DIR_S = 2;
  localparam int DIR_W = 3;

  typedef enum logic [1:0] {
    FN_COST  = 2'd0,
    FN_BLOCK = 2'd1,
    FN_DIR   = 2'd2,
    FN_NONE  = 2'd3
  } cell_fn_e;
endpackage

// File: rtl/wave_arrival.sv
module wave_arrival
  import wave_cell_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clear_i,
  input  logic            src_i,
  input  logic [NDIR-1:0] trig_i,
  output logic [NDIR-1:0] dir_o,
  output logic            reached_o,
  output logic            arr_o,
  output logic            src_go_o
);
  logic [NDIR-1:0] dir_q, dir_d, pick;
  logic            reached_q, reached_d, open_w;

  // lowest set bit wins
  always_comb begin
    pick = '0;
    for (int i = NDIR - 1; i >= 0; i--) begin
      if (trig_i[i]) pick = NDIR'(1) << i;
    end
  end

  assign open_w   = !reached_q && !clear_i;
  assign src_go_o = open_w && src_i;
  assign arr_o    = open_w && !src_i && (|trig_i);

  always_comb begin
    dir_d     = dir_q;
    reached_d = reached_q;
    if (clear_i) begin
      dir_d     = '0;
      reached_d = 1'b0;
    end else if (src_go_o) begin
      reached_d = 1'b1;
    end else if (arr_o) begin
      dir_d     = pick;
      reached_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q     <= '0;
      reached_q <= 1'b0;
    end else begin
      dir_q     <= dir_d;
      reached_q <= reached_d;
    end
  end

  assign dir_o     = dir_q;
  assign reached_o = reached_q;
endmodule

// File: rtl/wave_delay.sv
module wave_delay #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] preset_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             run_q, run_d;

  always_comb begin
    cnt_d = cnt_q;
    run_d = run_q;
    if (clear_i) begin
      cnt_d = '0;
      run_d = 1'b0;
    end else if (load_i) begin
      cnt_d = preset_i;
      run_d = 1'b1;
    end else if (run_q) begin
      if (cnt_q == '0) run_d = 1'b0;
      else             cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      run_q <= run_d;
    end
  end

  assign done_o = run_q && (cnt_q == '0);
endmodule

// File: rtl/wave_regs.sv
module wave_regs
  import wave_cell_pkg::*;
#(
  parameter int BUS_W = 4,
  localparam int COST_W = 2 * BUS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_i,
  input  logic              we_i,
  input  logic [1:0]        func_i,
  input  logic              nib_i,
  input  logic [BUS_W-1:0]  wdata_i,
  input  logic              lock_i,
  input  logic [NDIR-1:0]   dir_i,
  output logic [COST_W-1:0] cost_o,
  output logic [NDIR-1:0]   block_o,
  output logic [BUS_W-1:0]  rdata_o
);
  cell_fn_e        fn;
  logic            wr_cost, wr_block;
  logic [NDIR-1:0] block_q, block_d;

  assign fn       = cell_fn_e'(func_i);
  assign wr_cost  = sel_i && we_i && (fn == FN_COST) && !lock_i;
  assign wr_block = sel_i && we_i && (fn == FN_BLOCK);

  for (genvar g = 0; g < 2; g++) begin : g_nib
    logic [BUS_W-1:0] nib_q, nib_d;
    always_comb begin
      nib_d = nib_q;
      if (wr_cost && (nib_i == 1'(g))) nib_d = wdata_i;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) nib_q <= '0;
      else        nib_q <= nib_d;
    end
    assign cost_o[g*BUS_W +: BUS_W] = nib_q;
  end

  always_comb begin
    block_d = block_q;
    if (wr_block) block_d = wdata_i[NDIR-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) block_q <= '0;
    else        block_q <= block_d;
  end

  always_comb begin
    rdata_o = '0;
    if (sel_i) begin
      unique case (fn)
        FN_COST:  rdata_o = nib_i ? cost_o[COST_W-1:BUS_W] : cost_o[BUS_W-1:0];
        FN_BLOCK: rdata_o = BUS_W'(block_q);
        FN_DIR:   rdata_o = BUS_W'(dir_i);
        default:  rdata_o = '0;
      endcase
    end
  end

  assign block_o = block_q;
endmodule

// File: rtl/wave_cell.sv
module wave_cell
  import wave_cell_pkg::*;
#(
  parameter int BUS_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             src_i,
  input  logic [3:0]       trig_in_i,
  output logic [3:0]       trig_out_o,
  input  logic             sel_i,
  input  logic             we_i,
  input  logic [1:0]       func_i,
  input  logic             nib_i,
  input  logic [BUS_W-1:0] wdata_i,
  output logic [BUS_W-1:0] rdata_o
);
  localparam int COST_W = 2 * BUS_W;

  logic [NDIR-1:0]   dir_w, block_w;
  logic              reached_w, arr_w, src_go_w, done_w;
  logic [COST_W-1:0] cost_w, preset_w;

  wave_arrival u_arr (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear_i  (clear_i),
    .src_i    (src_i),
    .trig_i   (trig_in_i),
    .dir_o    (dir_w),
    .reached_o(reached_w),
    .arr_o    (arr_w),
    .src_go_o (src_go_w)
  );

  assign preset_w = src_go_w ? '0 : cost_w;

  wave_delay #(.CNT_W(COST_W)) u_dly (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (clear_i),
    .load_i  (arr_w || src_go_w),
    .preset_i(preset_w),
    .done_o  (done_w)
  );

  wave_regs #(.BUS_W(BUS_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel_i   (sel_i),
    .we_i    (we_i),
    .func_i  (func_i),
    .nib_i   (nib_i),
    .wdata_i (wdata_i),
    .lock_i  (reached_w),
    .dir_i   (dir_w),
    .cost_o  (cost_w),
    .block_o (block_w),
    .rdata_o (rdata_o)
  );

  assign trig_out_o = {NDIR{done_w}} & ~block_w;
endmodule

// File: rtl/wave_cell_chk.sv
module wave_cell_chk #(
  parameter int BUS_W = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               clear_i,
  input logic               src_i,
  input logic [3:0]         trig_in_i,
  input logic [3:0]         trig_out_o,
  input logic [3:0]         dir_w,
  input logic               reached_w,
  input logic [3:0]         block_w,
  input logic [2*BUS_W-1:0] cost_w
);
  assert_flag_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dir_w));

  assert_north_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!reached_w && !clear_i && !src_i && trig_in_i[0]) |=> (dir_w == 4'b0001));

  assert_lockout_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (reached_w && !clear_i) |=> ($stable(dir_w) && reached_w));

  assert_cost_locked_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reached_w && !clear_i) |=> $stable(cost_w));

  assert_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|trig_out_o) |=> (trig_out_o == 4'b0000));

  assert_zero_cost_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!reached_w && !clear_i && !src_i && (|trig_in_i) && (cost_w == '0))
      |=> (trig_out_o == ~block_w));

  assert_source_fire_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!reached_w && !clear_i && src_i) |=> ((trig_out_o == ~block_w) && (dir_w == 4'b0000)));

  assert_clear_wipes_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> ((dir_w == 4'b0000) && !reached_w && (trig_out_o == 4'b0000)));
endmodule

bind wave_cell wave_cell_chk #(.BUS_W(BUS_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .clear_i   (clear_i),
  .src_i     (src_i),
  .trig_in_i (trig_in_i),
  .trig_out_o(trig_out_o),
  .dir_w     (dir_w),
  .reached_w (reached_w),
  .block_w   (block_w),
  .cost_w    (cost_w)
);

// File: tb/sim_wave_cell.sv
`timescale 1ns/1ps
module sim_wave_cell;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clear_i = 1'b0, src_i = 1'b0, sel_i = 1'b0, we_i = 1'b0, nib_i = 1'b0;
  logic [3:0] trig_in_i = '0, wdata_i = '0;
  logic [1:0] func_i = '0;
  logic [3:0] trig_out_o, rdata_o;

  int    n_run = 0, n_fail = 0;
  string cur_req = "R1";
  bit    done = 1'b0;

  // event-time model
  logic [7:0] m_cost;
  logic [3:0] m_block, m_dir;
  bit         m_reached;
  int         m_fire, ecnt;

  always #2 clk = ~clk;

  wave_cell u0 (
    .clk(clk), .rst_n(rst_n), .clear_i(clear_i), .src_i(src_i),
    .trig_in_i(trig_in_i), .trig_out_o(trig_out_o), .sel_i(sel_i), .we_i(we_i),
    .func_i(func_i), .nib_i(nib_i), .wdata_i(wdata_i), .rdata_o(rdata_o)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cost = '0; m_block = '0; m_dir = '0; m_reached = 0; m_fire = -1; ecnt = 0;
    end else begin
      automatic bit         old_r = m_reached;
      automatic logic [7:0] old_c = m_cost;
      ecnt++;
      if (sel_i && we_i) begin
        if (func_i == 2'd0 && !old_r) begin
          if (nib_i) m_cost = {wdata_i, m_cost[3:0]};
          else       m_cost = {m_cost[7:4], wdata_i};
        end else if (func_i == 2'd1) m_block = wdata_i;
      end
      if (clear_i) begin
        m_reached = 0; m_dir = '0; m_fire = -1;
      end else if (!old_r) begin
        if (src_i) begin
          m_reached = 1; m_fire = ecnt;
        end else if (trig_in_i != 0) begin
          m_reached = 1;
          m_dir = trig_in_i[0] ? 4'b0001 : trig_in_i[1] ? 4'b0010 :
                  trig_in_i[2] ? 4'b0100 : 4'b1000;
          m_fire = ecnt + int'(old_c);
        end
      end
    end
  end

  function automatic logic [3:0] exp_rdata();
    if (!sel_i) return 4'h0;
    case (func_i)
      2'd0: return nib_i ? m_cost[7:4] : m_cost[3:0];
      2'd1: return m_block;
      2'd2: return m_dir;
      default: return 4'h0;
    endcase
  endfunction

  task automatic check(string what, logic [3:0] act, logic [3:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s act=%h exp=%h t=%0t", cur_req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("trig_out", trig_out_o, (m_fire == ecnt) ? ~m_block : 4'h0);
      check("rdata", rdata_o, exp_rdata());
    end
  end

  task automatic tick(int n = 1);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic wr(logic [1:0] f, logic nb, logic [3:0] d);
    sel_i = 1; we_i = 1; func_i = f; nib_i = nb; wdata_i = d;
    tick(); sel_i = 0; we_i = 0;
  endtask

  task automatic rd(logic [1:0] f, logic nb);
    sel_i = 1; we_i = 0; func_i = f; nib_i = nb;
    tick(); sel_i = 0;
  endtask

  task automatic trig(logic [3:0] t);
    trig_in_i = t; tick(); trig_in_i = '0;
  endtask

  task automatic clr();
    clear_i = 1; tick(); clear_i = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1; n_run++; n_fail++;
      $display("FAIL %s watchdog expired", cur_req);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    cur_req = "R1";
    tick(3);
    check("reset trig_out", trig_out_o, 4'h0);
    check("reset rdata", rdata_o, 4'h0);
    @(negedge clk); rst_n = 1; tick();
    rd(2'd0, 0); rd(2'd0, 1); rd(2'd1, 0); rd(2'd2, 0);

    // R2 cost nibbles
    cur_req = "R2";
    wr(2'd0, 0, 4'h5); wr(2'd0, 1, 4'h0); rd(2'd0, 0); rd(2'd0, 1);
    cur_req = "R6";
    wr(2'd1, 0, 4'h0);

    // R3 / R5 east arrival with cost 5; R9 read flags mid-countdown
    cur_req = "R5";
    trig(4'b0010);
    cur_req = "R9";
    rd(2'd2, 0);
    cur_req = "R5";
    tick(8);

    // R4 lockout and R2 cost lock
    cur_req = "R4";
    trig(4'b0001); tick(3); rd(2'd2, 0);
    cur_req = "R2";
    wr(2'd0, 0, 4'hF); rd(2'd0, 0);
    cur_req = "R10";
    wr(2'd2, 0, 4'hF); rd(2'd2, 0); wr(2'd3, 0, 4'hF); rd(2'd3, 0);

    // R8 clear keeps programming
    cur_req = "R8";
    clr(); rd(2'd2, 0); rd(2'd0, 0); rd(2'd1, 0);

    // R3 priority
    cur_req = "R3";
    trig(4'b1110); rd(2'd2, 0); tick(7); clr();
    trig(4'b1111); rd(2'd2, 0); tick(7); clr();
    trig(4'b1100); rd(2'd2, 0); tick(7); clr();
    trig(4'b1000); rd(2'd2, 0); tick(7); clr();

    // R5 zero cost
    cur_req = "R5";
    wr(2'd0, 0, 4'h0); trig(4'b1000); tick(3); clr();

    // R6 / R7 source with block mask
    cur_req = "R7";
    wr(2'd1, 0, 4'b0101);
    wr(2'd0, 0, 4'h9);
    src_i = 1; tick(); src_i = 0; tick(3); rd(2'd2, 0); clr();
    src_i = 1; trig_in_i = 4'b0010; tick(); src_i = 0; trig_in_i = '0;
    rd(2'd2, 0); tick(12); clr();
    cur_req = "R6";
    trig(4'b0100); tick(4); wr(2'd1, 0, 4'b1010); tick(8); clr();

    // R8 clear during countdown cancels the pulse, clear beats arrival
    cur_req = "R8";
    wr(2'd1, 0, 4'h0);
    wr(2'd0, 0, 4'hA); wr(2'd0, 1, 4'h3);
    trig(4'b0100); tick(5); clr(); tick(70);
    clear_i = 1; trig_in_i = 4'b0001; tick(); clear_i = 0; trig_in_i = '0;
    rd(2'd2, 0);

    // R5 long cost from high nibble
    cur_req = "R5";
    trig(4'b0100); tick(62); clr();

    // R9 deselected reads
    cur_req = "R9";
    sel_i = 0; func_i = 2'd0; tick(2);
    rd(2'd3, 1);

    tick(2);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule